// File: doc/BRIEF.md
# Serial Character Receiver with Error Flags

This block recovers characters from an asynchronous serial line. A tick input that runs at sixteen times the bit rate sets the sampling grid. The serial input first passes through a flop synchronizer. A falling edge then arms start-bit qualification, and each bit is sampled once, at the centre of its window. Each finished character goes into a receive queue together with three flags: a parity error flag, a framing error flag and a line-break flag.

The receive side of a serial port reads the queue head through a pop strobe. The block reports data-ready and a sticky overrun flag. It also raises a character-timeout indication when characters sit in the queue and nothing has happened for a few character times. The queue can be switched down to a single-entry holding register. Character length, parity enable and parity sense are static configuration inputs.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, data_ready_o, overrun_o and timeout_o are low.
- R2: A frame consists of a low start bit, then data bits LSB first, then an optional parity bit, then stop bits, each bit 16 ticks long. A correctly formed frame yields one queue entry with the data on rd_data_o and all three flags clear, and data_ready_o goes high.
- R3: word_len_i selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The unused upper bits of rd_data_o read as zero.
- R4: With par_en_i high, one parity bit follows the data. par_even_i high selects even parity and low selects odd parity. A mismatch sets rd_perr_o for that entry only.
- R5: Only the first stop bit is sampled. If it is low and the character is not a break, rd_ferr_o is set and rd_brk_o is clear.
- R6: A low pulse that has ended by the eighth tick after the falling edge is rejected as a false start. It produces no entry, and the next valid frame is received normally.
- R7: A break is declared when all data bits, the parity bit (if enabled) and the stop bit are low. It stores one entry with data 0, rd_brk_o set, and rd_ferr_o and rd_perr_o clear. A line that stays low afterwards stores no further entries until it has returned high.
- R8: The queue holds DEPTH entries (16 by default) and returns them in arrival order.
- R9: If a character completes while the queue is full, the character is discarded, the stored entries are left unchanged, and overrun_o is set. overrun_o stays set until the next pop of a non-empty queue.
- R10: With fifo_en_i low the queue holds a single entry. A second character that arrives before the first is read sets overrun_o, and the first character is kept.
- R11: timeout_o rises once the queue has been non-empty for TO_CHARS character times (4 by default) with no character completed and no pop. It clears on a pop.
- R12: rd_i on an empty queue has no effect. data_ready_o and overrun_o stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| word_len_i | input | 2 | Character length code (0..3 for 5..8 bits) |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | 1 selects even parity, 0 selects odd |
| fifo_en_i | input | 1 | 1 selects the full queue, 0 a single holding entry |
| rd_i | input | 1 | Pop the queue head |
| rd_data_o | output | 8 | Head entry data, zero-extended |
| rd_perr_o | output | 1 | Head entry parity error |
| rd_ferr_o | output | 1 | Head entry framing error |
| rd_brk_o | output | 1 | Head entry break |
| data_ready_o | output | 1 | Queue not empty |
| overrun_o | output | 1 | Sticky overrun flag |
| timeout_o | output | 1 | Character timeout |

## Verification
The bench builds the block with the defaults: DEPTH of 16, TO_CHARS of 4 and a two-stage synchronizer. A depth of 16 lets a run of seventeen back-to-back frames reach the overrun case and check the order of all stored entries. A four-character timeout at 8N1 takes 640 ticks, so the bench can check both sides of the timeout edge, one character time before it and shortly after it. The bench also drives all four character lengths, both parity senses, a low stop bit, a short glitch and a long low hold.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_char_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic [1:0] word_len_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  output logic       vld_o,
  output rx_char_t   char_o
);
  rx_state_e  state_q;
  logic [3:0] tcnt_q;
  logic [2:0] bcnt_q;
  logic [7:0] sh_q;
  logic       pbit_q;
  logic       prev_q;

  logic [7:0] data_al;
  logic [2:0] last_bit;
  logic       par_calc, is_brk;
  logic       mid;

  always_comb begin
    last_bit = 3'd4 + {1'b0, word_len_i};
    data_al  = sh_q >> (2'd3 - word_len_i);
    par_calc = (^data_al) ^ pbit_q;
    is_brk   = (data_al == 8'h00) && (!par_en_i || !pbit_q) && !line_i;
    mid      = tick_i && (tcnt_q == 4'd15);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      prev_q  <= 1'b1;
      vld_o   <= 1'b0;
      char_o  <= '0;
    end else begin
      prev_q <= line_i;
      vld_o  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (prev_q && !line_i) begin
            state_q <= ST_START;
            tcnt_q  <= '0;
          end
        end
        ST_START: begin
          if (tick_i) begin
            if (tcnt_q == 4'd7) begin
              tcnt_q <= '0;
              bcnt_q <= '0;
              // line high at the start-bit centre: glitch, resume hunting
              state_q <= line_i ? ST_IDLE : ST_DATA;
            end else begin
              tcnt_q <= tcnt_q + 4'd1;
            end
          end
        end
        ST_DATA: begin
          if (tick_i) tcnt_q <= tcnt_q + 4'd1;
          if (mid) begin
            sh_q   <= {line_i, sh_q[7:1]};
            bcnt_q <= bcnt_q + 3'd1;
            if (bcnt_q == last_bit) state_q <= par_en_i ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: begin
          if (tick_i) tcnt_q <= tcnt_q + 4'd1;
          if (mid) begin
            pbit_q  <= line_i;
            state_q <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (tick_i) tcnt_q <= tcnt_q + 4'd1;
          if (mid) begin
            vld_o       <= 1'b1;
            char_o.data <= data_al;
            char_o.brk  <= is_brk;
            char_o.ferr <= !line_i && !is_brk;
            char_o.perr <= par_en_i && !is_brk && (par_calc ^ !par_even_i);
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
  import rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          single_i,
  input  logic          push_i,
  input  rx_char_t      din_i,
  input  logic          pop_i,
  output rx_char_t      dout_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [LW-1:0] lvl_o
);
  rx_char_t      mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] lvl_q;
  logic          do_push, do_pop;

  assign empty_o = (lvl_q == '0);
  assign full_o  = single_i ? !empty_o : (lvl_q == LW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rptr_q];
  assign lvl_o   = lvl_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + AW'(1);
      if (do_pop)  rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + AW'(1);
      if (do_push && !do_pop)      lvl_q <= lvl_q + LW'(1);
      else if (do_pop && !do_push) lvl_q <= lvl_q - LW'(1);
    end
  end
endmodule

// File: rtl/rx_timeout.sv
module rx_timeout #(
  parameter int TO_CHARS = 4,
  localparam int CW = $clog2(TO_CHARS * 192 + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       active_i,
  input  logic       clr_i,
  input  logic [1:0] word_len_i,
  input  logic       par_en_i,
  output logic       to_o
);
  logic [CW-1:0] cnt_q, limit;

  // one character = start + (5+len) data + parity + first stop, 16 ticks each
  assign limit = CW'(TO_CHARS * 16) * (CW'(word_len_i) + CW'(par_en_i) + CW'(7));
  assign to_o  = active_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i || !active_i)     cnt_q <= '0;
    else if (tick_i && cnt_q < limit) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import rx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int TO_CHARS    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick16_i,
  input  logic       rxd_i,
  input  logic [1:0] word_len_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       fifo_en_i,
  input  logic       rd_i,
  output logic [7:0] rd_data_o,
  output logic       rd_perr_o,
  output logic       rd_ferr_o,
  output logic       rd_brk_o,
  output logic       data_ready_o,
  output logic       overrun_o,
  output logic       timeout_o
);
  logic          line_s;
  logic          char_done;
  rx_char_t      char_d, head;
  logic          fifo_full, fifo_empty, pop_ok;
  logic [LW-1:0] fifo_lvl;
  logic          ovr_q;

  rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i, .rst_ni, .d_i(rxd_i), .q_o(line_s)
  );

  rx_frame frame_i (
    .clk_i, .rst_ni,
    .tick_i(tick16_i), .line_i(line_s),
    .word_len_i, .par_en_i, .par_even_i,
    .vld_o(char_done), .char_o(char_d)
  );

  rx_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk_i, .rst_ni,
    .single_i(!fifo_en_i),
    .push_i(char_done), .din_i(char_d),
    .pop_i(rd_i), .dout_o(head),
    .empty_o(fifo_empty), .full_o(fifo_full), .lvl_o(fifo_lvl)
  );

  assign pop_ok = rd_i && !fifo_empty;

  rx_timeout #(.TO_CHARS(TO_CHARS)) tmo_i (
    .clk_i, .rst_ni,
    .tick_i(tick16_i), .active_i(!fifo_empty),
    .clr_i(char_done || pop_ok),
    .word_len_i, .par_en_i,
    .to_o(timeout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ovr_q <= 1'b0;
    else if (char_done && fifo_full) ovr_q <= 1'b1;
    else if (pop_ok)                 ovr_q <= 1'b0;
  end

  assign overrun_o    = ovr_q;
  assign data_ready_o = !fifo_empty;
  assign rd_data_o    = head.data;
  assign rd_perr_o    = head.perr;
  assign rd_ferr_o    = head.ferr;
  assign rd_brk_o     = head.brk;
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_i,
  input logic          char_done,
  input logic          fifo_full,
  input logic [LW-1:0] fifo_lvl,
  input logic          data_ready_o,
  input logic          overrun_o,
  input logic          timeout_o,
  input logic [7:0]    rd_data_o,
  input logic          rd_perr_o,
  input logic          rd_ferr_o,
  input logic          rd_brk_o
);
  a_r9_ovr_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(char_done && fifo_full));

  a_r9_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !(rd_i && data_ready_o) |=> overrun_o);

  a_r9_full_no_grow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_done && fifo_full && !(rd_i && data_ready_o) |=> $stable(fifo_lvl));

  a_r8_lvl_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_lvl <= LW'(DEPTH));

  a_r11_to_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> data_ready_o);

  a_r7_brk_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o && rd_brk_o |-> (rd_data_o == 8'h00) && !rd_ferr_o && !rd_perr_o);

  a_r12_empty_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_ready_o && !char_done |=> !data_ready_o);
endmodule

bind uart_rx_core uart_rx_core_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i),
  .char_done(char_done), .fifo_full(fifo_full), .fifo_lvl(fifo_lvl),
  .data_ready_o(data_ready_o), .overrun_o(overrun_o), .timeout_o(timeout_o),
  .rd_data_o(rd_data_o), .rd_perr_o(rd_perr_o), .rd_ferr_o(rd_ferr_o),
  .rd_brk_o(rd_brk_o)
);

// File: tb/uart_rx_core_tb_top.sv
`timescale 1ns/1ps
module uart_rx_core_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick16_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic [1:0] word_len_i = 2'd3;
  logic       par_en_i = 1'b0;
  logic       par_even_i = 1'b0;
  logic       fifo_en_i = 1'b1;
  logic       rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       rd_perr_o, rd_ferr_o, rd_brk_o;
  logic       data_ready_o, overrun_o, timeout_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [1:0] tdiv = '0;

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    tdiv     <= tdiv + 2'd1;
    tick16_i <= (tdiv == 2'd3);
  end

  uart_rx_core dut_i (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int ticks);
    rxd_i = v;
    repeat (ticks * 4) @(negedge clk_i);
  endtask

  task automatic send(input logic [7:0] d, input int nbits, input bit pe, input bit ev,
                      input bit flip, input bit stop_v);
    logic p;
    word_len_i = 2'(nbits - 5);
    par_en_i   = pe;
    par_even_i = ev;
    p = 1'b0;
    drive(1'b0, 16);
    for (int i = 0; i < nbits; i++) begin
      drive(d[i], 16);
      p = p ^ d[i];
    end
    if (pe) drive((ev ? p : ~p) ^ flip, 16);
    drive(stop_v, 16);
    drive(1'b1, 16);
  endtask

  task automatic expect_char(input logic [7:0] d, input bit pe_f, input bit fe_f,
                             input bit bk_f, input string tag);
    @(negedge clk_i);
    check(data_ready_o === 1'b1, {tag, " ready"}, data_ready_o, 1);
    check(rd_data_o === d, {tag, " data"}, rd_data_o, d);
    check({rd_perr_o, rd_ferr_o, rd_brk_o} === {pe_f, fe_f, bk_f}, {tag, " flags"},
          {rd_perr_o, rd_ferr_o, rd_brk_o}, {pe_f, fe_f, bk_f});
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    check({data_ready_o, overrun_o, timeout_o} === 3'b000, "R1 reset state",
          {data_ready_o, overrun_o, timeout_o}, 0);
  endtask

  task automatic t_basic;
    send(8'hA5, 8, 0, 0, 0, 1);
    expect_char(8'hA5, 0, 0, 0, "R2 8N1 a5");
    send(8'h3C, 8, 0, 0, 0, 1);
    drive(1'b1, 16); // second stop bit
    expect_char(8'h3C, 0, 0, 0, "R2 8N2 3c");
  endtask

  task automatic t_lengths;
    for (int n = 5; n <= 8; n++) begin
      send(8'hD6, n, 0, 0, 0, 1);
      expect_char(8'hD6 & 8'((1 << n) - 1), 0, 0, 0, $sformatf("R3 len %0d", n));
    end
  endtask

  task automatic t_parity;
    send(8'h37, 8, 1, 1, 0, 1); expect_char(8'h37, 0, 0, 0, "R4 even ok");
    send(8'h37, 8, 1, 1, 1, 1); expect_char(8'h37, 1, 0, 0, "R4 even bad");
    send(8'h81, 8, 1, 0, 0, 1); expect_char(8'h81, 0, 0, 0, "R4 odd ok");
    send(8'h81, 8, 1, 0, 1, 1); expect_char(8'h81, 1, 0, 0, "R4 odd bad");
    send(8'h15, 7, 1, 1, 1, 1); expect_char(8'h15, 1, 0, 0, "R4 7bit even bad");
  endtask

  task automatic t_framing;
    send(8'h55, 8, 0, 0, 0, 0);
    expect_char(8'h55, 0, 1, 0, "R5 low stop");
  endtask

  task automatic t_false_start;
    word_len_i = 2'd3; par_en_i = 1'b0;
    drive(1'b0, 4);
    drive(1'b1, 40);
    check(data_ready_o === 1'b0, "R6 glitch ignored", data_ready_o, 0);
    send(8'h81, 8, 0, 0, 0, 1);
    expect_char(8'h81, 0, 0, 0, "R6 after glitch");
  endtask

  task automatic t_break;
    word_len_i = 2'd3; par_en_i = 1'b0;
    drive(1'b0, 480);
    drive(1'b1, 20);
    expect_char(8'h00, 0, 0, 1, "R7 break entry");
    @(negedge clk_i);
    check(data_ready_o === 1'b0, "R7 single break entry", data_ready_o, 0);
  endtask

  task automatic t_fifo;
    for (int i = 0; i < 16; i++) send(8'(i * 7 + 1), 8, 0, 0, 0, 1);
    check(overrun_o === 1'b0, "R9 no overrun at full", overrun_o, 0);
    send(8'hEE, 8, 0, 0, 0, 1);
    check(overrun_o === 1'b1, "R9 overrun set", overrun_o, 1);
    for (int i = 0; i < 16; i++) begin
      expect_char(8'(i * 7 + 1), 0, 0, 0, $sformatf("R8 order %0d", i));
      if (i == 0) check(overrun_o === 1'b0, "R9 overrun cleared", overrun_o, 0);
    end
    @(negedge clk_i);
    check(data_ready_o === 1'b0, "R9 17th discarded", data_ready_o, 0);
  endtask

  task automatic t_nofifo;
    fifo_en_i = 1'b0;
    send(8'h11, 8, 0, 0, 0, 1);
    send(8'h22, 8, 0, 0, 0, 1);
    check(overrun_o === 1'b1, "R10 single-entry overrun", overrun_o, 1);
    expect_char(8'h11, 0, 0, 0, "R10 first kept");
    @(negedge clk_i);
    check(data_ready_o === 1'b0, "R10 empty after read", data_ready_o, 0);
    fifo_en_i = 1'b1;
  endtask

  task automatic t_timeout;
    send(8'h5A, 8, 0, 0, 0, 1);
    repeat (1800) @(negedge clk_i);
    check(timeout_o === 1'b0, "R11 no early timeout", timeout_o, 0);
    repeat (800) @(negedge clk_i);
    check(timeout_o === 1'b1, "R11 timeout raised", timeout_o, 1);
    expect_char(8'h5A, 0, 0, 0, "R11 data");
    check(timeout_o === 1'b0, "R11 cleared by pop", timeout_o, 0);
  endtask

  task automatic t_empty_pop;
    @(negedge clk_i);
    rd_i = 1'b1;
    repeat (3) @(negedge clk_i);
    rd_i = 1'b0;
    check({data_ready_o, overrun_o} === 2'b00, "R12 pop on empty",
          {data_ready_o, overrun_o}, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    repeat (40) @(negedge clk_i);
    t_basic();
    t_lengths();
    t_parity();
    t_framing();
    t_false_start();
    t_break();
    t_fifo();
    t_nofifo();
    t_timeout();
    t_empty_pop();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule